// File: doc/BRIEF.md
# Split-Format Vector Accumulator

This block holds a 192-bit signed accumulator and the datapath that updates it from packed 64-bit vector operands. The storage is partitioned according to the element format chosen for each operation: with byte elements it acts as eight lanes of 24 bits, and with halfword elements it acts as four lanes of 48 bits. Each lane is three times the element width. The extra width absorbs products and long running sums.

A processor pipeline issues at most one operation per cycle, marked by a valid strobe. The operation comes with the first vector and with a second vector that has already been through operand selection. Arithmetic operations multiply or add the elements of the two vectors lane by lane. Each one either replaces the lane or adds to or subtracts from it.

Slice operations move data between the lanes and the vector width. A read returns the low, middle or high third of every lane, packed into a 64-bit result. A write loads the top third of every lane from the first vector. The lower two thirds are either kept or taken from the second vector. Rounding and clamping of the accumulator into a result vector happen elsewhere.

Top module: `vector_acc`

## Requirements
- R1: While reset is asserted, all 192 accumulator bits and the 64-bit read result are zero.
- R2: With fmt_qh=0, lane i occupies accumulator bits [24i+23:24i] and pairs with operand bits [8i+7:8i]. With fmt_qh=1, lane i occupies bits [48i+47:48i] and pairs with operand bits [16i+15:16i]. Operand elements are two's-complement signed values.
- R3: The multiply codes work per lane on the elements a (vs_data) and b (vt_data): 0 gives acc+a*b, 1 gives acc-a*b, 2 gives a*b, and 3 gives -(a*b).
- R4: The add and difference codes work per lane: 4 gives acc+a+b, 5 gives a+b, 6 gives acc+a-b, and 7 gives a-b.
- R5: Lane arithmetic wraps modulo 2^(3w), where w is 8 or 16. There is no saturation and no carry or borrow between lanes.
- R6: Read codes 8, 9 and 10 place lane bits [w-1:0], [2w-1:w] or [3w-1:2w], respectively, into rd_data bits [w*i+w-1:w*i]. The accumulator is unchanged.
- R7: Write-high code 11 sets lane bits [3w-1:2w] to the a element and keeps lane bits [2w-1:0].
- R8: Write-low code 12 sets lane bits [3w-1:2w] to the a element and lane bits [2w-1:0] to the b element sign-extended to 2w bits.
- R9: Every update is visible on acc_state, and every read result on rd_data, on the cycle after the strobe. With op_valid low, both outputs hold. rd_data changes only after a read code.
- R10: Codes 13 to 15 change neither acc_state nor rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (R3, R4, R6 to R8, R10) |
| fmt_qh | input | 1 | 0: byte elements in 24-bit lanes; 1: halfword elements in 48-bit lanes |
| vs_data | input | 64 | First packed operand (a) |
| vt_data | input | 64 | Second packed operand (b), already selected |
| acc_state | output | 192 | Registered accumulator contents |
| rd_data | output | 64 | Registered result of the last read operation |

## Verification
The hardest case to reach is a carry out of a 48-bit lane, or a wrap of that lane. Accumulating small random products would take far too many cycles to get close to the lane limit. The stimulus therefore uses write-low to load a lane with its largest positive value in one operation, and then adds one to it. A second directed sequence loads the byte lanes and reads them back with halfword reads, so the same storage is checked in both partitions. Random codes, formats and operands then run against a bench model that works lane by lane.

// File: rtl/vacc_pkg.sv
package vacc_pkg;

    typedef enum logic [3:0] {
        OP_MAC_ADD  = 4'd0,
        OP_MAC_SUB  = 4'd1,
        OP_MUL_LD   = 4'd2,
        OP_MUL_NLD  = 4'd3,
        OP_ADD_ACC  = 4'd4,
        OP_ADD_LD   = 4'd5,
        OP_DIF_ACC  = 4'd6,
        OP_DIF_LD   = 4'd7,
        OP_RD_LO    = 4'd8,
        OP_RD_MID   = 4'd9,
        OP_RD_HI    = 4'd10,
        OP_WR_HI    = 4'd11,
        OP_WR_LO    = 4'd12
    } vacc_op_e;

    function automatic logic op_is_read(input vacc_op_e op);
        return (op == OP_RD_LO) || (op == OP_RD_MID) || (op == OP_RD_HI);
    endfunction

endpackage

// File: rtl/vacc_lane.sv
module vacc_lane
    import vacc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3*W-1:0] acc_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  vacc_op_e       op_i,
    output logic [3*W-1:0] nxt_o,
    output logic [W-1:0]   rd_o
);
    localparam int L = 3 * W;

    logic signed [W-1:0]   a_s;
    logic signed [W-1:0]   b_s;
    logic signed [2*W-1:0] prod;
    logic [L-1:0]          prod_x;
    logic [L-1:0]          a_x;
    logic [L-1:0]          b_x;

    assign a_s    = a_i;
    assign b_s    = b_i;
    assign prod   = a_s * b_s;
    assign prod_x = {{W{prod[2*W-1]}}, prod};
    assign a_x    = {{(2*W){a_i[W-1]}}, a_i};
    assign b_x    = {{(2*W){b_i[W-1]}}, b_i};

    always_comb begin
        nxt_o = acc_i;
        rd_o  = acc_i[W-1:0];
        unique case (op_i)
            OP_MAC_ADD: nxt_o = acc_i + prod_x;
            OP_MAC_SUB: nxt_o = acc_i - prod_x;
            OP_MUL_LD:  nxt_o = prod_x;
            OP_MUL_NLD: nxt_o = -prod_x;
            OP_ADD_ACC: nxt_o = acc_i + a_x + b_x;
            OP_ADD_LD:  nxt_o = a_x + b_x;
            OP_DIF_ACC: nxt_o = acc_i + a_x - b_x;
            OP_DIF_LD:  nxt_o = a_x - b_x;
            OP_RD_LO:   rd_o  = acc_i[W-1:0];
            OP_RD_MID:  rd_o  = acc_i[2*W-1:W];
            OP_RD_HI:   rd_o  = acc_i[L-1:2*W];
            OP_WR_HI:   nxt_o = {a_i, acc_i[2*W-1:0]};
            OP_WR_LO:   nxt_o = {a_i, b_x[2*W-1:0]};
            default:    nxt_o = acc_i;
        endcase
    end

endmodule

// File: rtl/vacc_segment.sv
module vacc_segment
    import vacc_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic [6*EW-1:0] acc_i,
    input  logic [2*EW-1:0] a_i,
    input  logic [2*EW-1:0] b_i,
    input  vacc_op_e        op_i,
    input  logic            fmt_qh_i,
    output logic [6*EW-1:0] nxt_o,
    output logic [2*EW-1:0] rd_o
);
    localparam int NL = 3 * EW;

    logic [6*EW-1:0] qh_nxt;
    logic [2*EW-1:0] qh_rd;
    logic [6*EW-1:0] ob_nxt;
    logic [2*EW-1:0] ob_rd;

    vacc_lane #(.W(2*EW)) wide_i (
        .acc_i (acc_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op_i),
        .nxt_o (qh_nxt),
        .rd_o  (qh_rd)
    );

    for (genvar j = 0; j < 2; j++) begin : g_narrow
        vacc_lane #(.W(EW)) narrow_i (
            .acc_i (acc_i[j*NL +: NL]),
            .a_i   (a_i[j*EW +: EW]),
            .b_i   (b_i[j*EW +: EW]),
            .op_i  (op_i),
            .nxt_o (ob_nxt[j*NL +: NL]),
            .rd_o  (ob_rd[j*EW +: EW])
        );
    end

    assign nxt_o = fmt_qh_i ? qh_nxt : ob_nxt;
    assign rd_o  = fmt_qh_i ? qh_rd  : ob_rd;

endmodule

// File: rtl/vector_acc.sv
module vector_acc
    import vacc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int OB_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [3:0]                  op_code,
    input  logic                        fmt_qh,
    input  logic [DATA_W-1:0]           vs_data,
    input  logic [DATA_W-1:0]           vt_data,
    output logic [3*DATA_W-1:0]         acc_state,
    output logic [DATA_W-1:0]           rd_data
);
    localparam int QH_W  = 2 * OB_W;
    localparam int SEG_W = 3 * QH_W;
    localparam int NSEG  = DATA_W / QH_W;
    localparam int ACC_W = NSEG * SEG_W;

    vacc_op_e          op_e;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_nxt;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] rd_nxt;
    logic              rd_take;

    assign op_e    = vacc_op_e'(op_code);
    assign rd_take = op_valid && op_is_read(op_e);

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        vacc_segment #(.EW(OB_W)) seg_i (
            .acc_i    (acc_q[s*SEG_W +: SEG_W]),
            .a_i      (vs_data[s*QH_W +: QH_W]),
            .b_i      (vt_data[s*QH_W +: QH_W]),
            .op_i     (op_e),
            .fmt_qh_i (fmt_qh),
            .nxt_o    (acc_nxt[s*SEG_W +: SEG_W]),
            .rd_o     (rd_nxt[s*QH_W +: QH_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            rd_q  <= '0;
        end else begin
            if (op_valid) acc_q <= acc_nxt;
            if (rd_take)  rd_q  <= rd_nxt;
        end
    end

    assign acc_state = acc_q;
    assign rd_data   = rd_q;

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_state) && $stable(rd_data)));

    // R6
    read_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code inside {4'd8, 4'd9, 4'd10}) |=> $stable(acc_state));

    // R9
    nonread_keeps_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !(op_code inside {4'd8, 4'd9, 4'd10})) |=> $stable(rd_data));

    // R10
    spare_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd13) |=> $stable(acc_state));

    // R7
    wrhi_low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd11 && fmt_qh)
        |=> (acc_state[2*QH_W-1:0] == $past(acc_state[2*QH_W-1:0])));

    // R8
    wrlo_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd12 && !fmt_qh)
        |=> (acc_state[3*OB_W-1:2*OB_W] == $past(vs_data[OB_W-1:0])));

endmodule

// File: tb/vector_acc_tb.sv
`timescale 1ns/1ps
module vector_acc_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = '0;
    logic         fmt_qh = 1'b0;
    logic [63:0]  vs_data = '0;
    logic [63:0]  vt_data = '0;
    logic [191:0] acc_state;
    logic [63:0]  rd_data;

    logic [191:0] exp_acc = '0;
    logic [63:0]  exp_rd = '0;
    int           n_chk = 0;
    int           n_fail = 0;

    always #2.5 clk = ~clk;

    vector_acc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .fmt_qh    (fmt_qh),
        .vs_data   (vs_data),
        .vt_data   (vt_data),
        .acc_state (acc_state),
        .rd_data   (rd_data)
    );

    function automatic longint msk(input int n);
        return (longint'(1) <<< n) - 1;
    endfunction

    function automatic longint sx(input longint v, input int n);
        if (((v >>> (n - 1)) & 1) != 0) return v - (longint'(1) <<< n);
        return v;
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        if (op <= 4'd3)  return "R3";
        if (op <= 4'd7)  return "R4";
        if (op <= 4'd10) return "R6";
        if (op == 4'd11) return "R7";
        if (op == 4'd12) return "R8";
        return "R10";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Bench model: per-lane update from the requirements (R2, R5)
    task automatic model(input logic [3:0] op, input logic fmt,
                         input logic [63:0] a, input logic [63:0] b);
        int w = fmt ? 16 : 8;
        int lw = 3 * w;
        int n = fmt ? 4 : 8;
        logic [191:0] nacc = '0;
        logic [63:0]  nrd = '0;
        for (int i = 0; i < n; i++) begin
            logic [191:0] t = exp_acc >> (i * lw);
            longint lv = longint'(t[63:0]) & msk(lw);
            longint ae = sx((longint'(a) >>> (i * w)) & msk(w), w);
            longint be = sx((longint'(b) >>> (i * w)) & msk(w), w);
            longint r = lv;
            longint sl = 0;
            case (op)
                4'd0:  r = lv + ae * be;
                4'd1:  r = lv - ae * be;
                4'd2:  r = ae * be;
                4'd3:  r = -(ae * be);
                4'd4:  r = lv + ae + be;
                4'd5:  r = ae + be;
                4'd6:  r = lv + ae - be;
                4'd7:  r = ae - be;
                4'd8:  sl = lv & msk(w);
                4'd9:  sl = (lv >>> w) & msk(w);
                4'd10: sl = (lv >>> (2 * w)) & msk(w);
                4'd11: r = ((ae & msk(w)) <<< (2 * w)) | (lv & msk(2 * w));
                4'd12: r = ((ae & msk(w)) <<< (2 * w)) | (be & msk(2 * w));
                default: r = lv;
            endcase
            nacc = nacc | (192'(r & msk(lw)) << (i * lw));
            nrd  = nrd | (64'(sl) << (i * w));
        end
        exp_acc = nacc;
        if (op >= 4'd8 && op <= 4'd10) exp_rd = nrd;
    endtask

    task automatic apply(input string tag, input logic [3:0] op, input logic fmt,
                         input logic [63:0] a, input logic [63:0] b);
        string t = (tag == "") ? tag_of(op) : tag;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; fmt_qh = fmt; vs_data = a; vt_data = b;
        model(op, fmt, a, b);
        @(negedge clk);
        op_valid = 1'b0;
        check(t, "acc", acc_state, exp_acc);
        check(t, "rd", {128'b0, rd_data}, {128'b0, exp_rd});
    endtask

    task automatic idle_check(input logic [63:0] a);
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd5; vs_data = a; vt_data = ~a;
        @(negedge clk);
        check("R9", "idle acc", acc_state, exp_acc);
        check("R9", "idle rd", {128'b0, rd_data}, {128'b0, exp_rd});
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        check("R1", "reset acc", acc_state, '0);
        check("R1", "reset rd", {128'b0, rd_data}, '0);
        rst_n = 1'b1;

        // R3: most negative bytes squared, then accumulate and subtract
        apply("R3", 4'd2, 1'b0, {8{8'h80}}, {8{8'h80}});
        apply("R3", 4'd0, 1'b0, 64'h7F01_FF80_0203_7F80, 64'h7F7F_0180_FE03_8180);
        apply("R3", 4'd3, 1'b1, 64'h8000_7FFF_FFFF_1234, 64'h8000_8000_0002_FFFE);
        apply("R3", 4'd1, 1'b1, 64'h8000_0001_7FFF_0003, 64'h7FFF_8000_7FFF_FFFD);
        // R4
        apply("R4", 4'd5, 1'b0, 64'h8080_7F7F_0102_FF00, 64'h80FF_7F01_FF02_0180);
        apply("R4", 4'd6, 1'b0, 64'h8000_7F01_1020_3040, 64'h7F01_8000_0102_0304);
        apply("R4", 4'd7, 1'b1, 64'h8000_7FFF_0000_1234, 64'h7FFF_8000_0001_4321);
        // R8, R5: lanes at their positive limit, then one more wraps
        apply("R8", 4'd12, 1'b1, {4{16'h7FFF}}, {4{16'hFFFF}});
        apply("R5", 4'd4, 1'b1, 64'h0001_0001_0001_0001, 64'h0);
        apply("R6", 4'd10, 1'b1, 64'h0, 64'h0);
        apply("R6", 4'd8, 1'b1, 64'h0, 64'h0);
        // R5: byte lanes wrap without carry into neighbours
        apply("R8", 4'd12, 1'b0, {8{8'h7F}}, {8{8'hFF}});
        apply("R5", 4'd4, 1'b0, {8{8'h01}}, 64'h0);
        // R2: same storage read back in halfword partition
        apply("R2", 4'd9, 1'b1, 64'h0, 64'h0);
        apply("R6", 4'd10, 1'b0, 64'h0, 64'h0);
        // R7
        apply("R7", 4'd11, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF);
        apply("R7", 4'd11, 1'b1, 64'hFEDC_BA98_7654_3210, 64'h0);
        apply("R6", 4'd9, 1'b0, 64'h0, 64'h0);
        // R10: spare codes with busy operands
        apply("R10", 4'd13, 1'b0, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1234_5678_9ABC_DEF0);
        apply("R10", 4'd15, 1'b1, 64'hFFFF_0000_FFFF_0000, 64'h0F0F_0F0F_0F0F_0F0F);
        idle_check(64'hA5A5_5A5A_A5A5_5A5A);

        for (int k = 0; k < 400; k++) begin
            logic [3:0]  op = 4'($urandom_range(0, 15));
            logic        fm = 1'($urandom_range(0, 1));
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom};
            apply("", op, fm, a, b);
            if (k % 50 == 0) idle_check(a ^ b);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule